// File: doc/BRIEF.md
# Muon Sector Candidate Pipeline

This block takes the muon trigger candidates of one detector sector every bunch crossing and reduces them to the two candidates with the highest momentum. It does this through five registered stages in a fixed order:

1. A low-momentum cut.
2. A coincidence check against a per-candidate hadron-calorimeter tag.
3. Removal of candidates that appear twice where neighbouring sectors overlap.
4. Selection of the highest-momentum survivor.
5. Selection of the second-highest survivor.

The result leaves as one 32-bit word per clock.

Each candidate has the following fields:
- a valid bit,
- a 3-bit momentum threshold code,
- an overlap flag,
- an 8-bit region-of-interest index.

`NUM_CAND` candidates enter side by side on one flat bus, together with one calorimeter tag bit per candidate. The output is meant to be forwarded to a downstream multiplicity and interface stage. Upstream logic can present a fresh candidate set on every clock.

Top module: `msp_sector_pipe`

## Requirements
- R1: While `rst_n` is low, `word_out` is all zeros. In the five clocks after reset is released, before the first sampled candidate set has crossed the pipeline, `word_out` is also all zeros.
- R2: A candidate set sampled at a rising clock edge produces its result on `word_out` after the fifth rising edge, counting that edge as the first. A new set is accepted on every edge, with no gaps.
- R3: Candidate i occupies `cand_in[i*13 +: 13]` with this layout: bit 12 valid, bits 11:9 momentum code, bit 8 overlap flag, bits 7:0 region index. A valid candidate whose momentum code is below `MIN_PT` (default 2) is discarded.
- R4: A surviving candidate whose code is below `CALO_PT` (default 5) is discarded unless `calo_tag_in[i]` is 1. Candidates with code `CALO_PT` or higher pass whether or not they are tagged.
- R5: Candidates 2k and 2k+1 form an overlap pair. When both still survive and both carry the overlap flag, only one of them is kept. The higher momentum code wins; on equal codes the lower index is kept.
- R6: Slot A holds the surviving candidate with the highest momentum code. Among equal codes, the lowest index wins.
- R7: Slot B holds the highest surviving candidate other than the one in slot A, using the same tie rule. Slot B is never valid unless slot A is valid, and its code never exceeds slot A's code.
- R8: Slot A sits in `word_out[15:0]` and slot B in `word_out[31:16]`. Each slot is laid out as {3'b000, the 13-bit candidate}. A slot with no candidate is all zeros.
- R9: The overlap stage leaves both members of a pair untouched when fewer than two of them carry the overlap flag or fewer than two of them survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_in | input | NUM_CAND*13 | Candidate set for this crossing |
| calo_tag_in | input | NUM_CAND | Hadron-calorimeter coincidence tag, one bit per candidate |
| word_out | output | 32 | Packed top-two result |

## Verification
Every result is due exactly five clocks after its candidate set is sampled, and that holds for every requirement, since the filter, coincidence and overlap rules all show up only through the final word. The bench drives inputs on falling edges. It queues the expected word it computes for each applied set, pre-loaded with five all-zero words for the reset window. At every falling edge it pops the queue entry pushed five steps earlier and compares it with `word_out`. Because the queue depth is fixed at five, the checks keep pace with back-to-back streams as well as with isolated corner cases.

// File: rtl/msp_pkg.sv
package msp_pkg;
    localparam int PT_W   = 3;
    localparam int ROI_W  = 8;
    localparam int SLOT_W = 16;

    typedef struct packed {
        logic             vld;
        logic [PT_W-1:0]  pt;
        logic             ovl;
        logic [ROI_W-1:0] roi;
    } cand_t;

    localparam int CAND_W = $bits(cand_t);
    localparam int PAD_W  = SLOT_W - CAND_W;
endpackage

// File: rtl/msp_pick_max.sv
module msp_pick_max
    import msp_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  cand_t [N-1:0]    cands,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [PT_W-1:0] best_pt;

    // Strictly-greater compare on an ascending scan keeps the lowest index on ties
    always_comb begin
        hit     = 1'b0;
        idx     = '0;
        best_pt = '0;
        for (int i = 0; i < N; i++) begin
            if (cands[i].vld && (!hit || cands[i].pt > best_pt)) begin
                hit     = 1'b1;
                idx     = IDX_W'(i);
                best_pt = cands[i].pt;
            end
        end
    end
endmodule

// File: rtl/msp_overlap_pair.sv
module msp_overlap_pair
    import msp_pkg::*;
(
    input  cand_t lo_i,
    input  cand_t hi_i,
    output cand_t lo_o,
    output cand_t hi_o
);
    logic clash;

    always_comb begin
        clash = lo_i.vld && hi_i.vld && lo_i.ovl && hi_i.ovl;
        lo_o  = lo_i;
        hi_o  = hi_i;
        if (clash) begin
            // Lower index survives an equal code
            if (hi_i.pt > lo_i.pt) lo_o.vld = 1'b0;
            else                   hi_o.vld = 1'b0;
        end
    end
endmodule

// File: rtl/msp_sector_pipe.sv
module msp_sector_pipe
    import msp_pkg::*;
#(
    parameter int NUM_CAND = 4,
    parameter int MIN_PT   = 2,
    parameter int CALO_PT  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CAND*CAND_W-1:0] cand_in,
    input  logic [NUM_CAND-1:0]        calo_tag_in,
    output logic [31:0]                word_out
);
    localparam int IDX_W     = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1;
    localparam int NUM_PAIRS = NUM_CAND / 2;
    localparam logic [PT_W-1:0] MIN_PT_V  = PT_W'(MIN_PT);
    localparam logic [PT_W-1:0] CALO_PT_V = PT_W'(CALO_PT);

    typedef struct packed {
        cand_t [NUM_CAND-1:0] s1;    // after low-momentum cut
        logic  [NUM_CAND-1:0] t1;    // tags travelling with s1
        cand_t [NUM_CAND-1:0] s2;    // after calorimeter coincidence
        cand_t [NUM_CAND-1:0] s3;    // after overlap removal
        cand_t                win;   // first pick
        cand_t [NUM_CAND-1:0] rest;  // set without first pick
        logic  [31:0]         word;  // packed result
    } pipe_t;

    pipe_t q, d;

    cand_t [NUM_CAND-1:0] ovl_res;
    logic                 hit_a, hit_b;
    logic [IDX_W-1:0]     idx_a, idx_b;

    // Stage 3 pairing
    genvar k;
    generate
        for (k = 0; k < NUM_PAIRS; k++) begin : g_pair
            msp_overlap_pair i_pair (
                .lo_i (q.s2[2*k]),
                .hi_i (q.s2[2*k+1]),
                .lo_o (ovl_res[2*k]),
                .hi_o (ovl_res[2*k+1])
            );
        end
        if (NUM_CAND % 2 == 1) begin : g_odd
            assign ovl_res[NUM_CAND-1] = q.s2[NUM_CAND-1];
        end
    endgenerate

    msp_pick_max #(.N(NUM_CAND), .IDX_W(IDX_W)) i_pick_a (
        .cands (q.s3),
        .hit   (hit_a),
        .idx   (idx_a)
    );

    msp_pick_max #(.N(NUM_CAND), .IDX_W(IDX_W)) i_pick_b (
        .cands (q.rest),
        .hit   (hit_b),
        .idx   (idx_b)
    );

    always_comb begin
        cand_t second;
        d = q;

        // Stage 1: low-momentum cut
        for (int i = 0; i < NUM_CAND; i++) begin
            d.s1[i] = cand_in[i*CAND_W +: CAND_W];
            if (d.s1[i].pt < MIN_PT_V) d.s1[i].vld = 1'b0;
            d.t1[i] = calo_tag_in[i];
        end

        // Stage 2: calorimeter coincidence for the lower codes
        for (int i = 0; i < NUM_CAND; i++) begin
            d.s2[i] = q.s1[i];
            if (q.s1[i].pt < CALO_PT_V && !q.t1[i]) d.s2[i].vld = 1'b0;
        end

        // Stage 3: overlap removal
        d.s3 = ovl_res;

        // Stage 4: highest candidate
        d.rest = q.s3;
        d.win  = '0;
        if (hit_a) begin
            d.win             = q.s3[idx_a];
            d.rest[idx_a].vld = 1'b0;
        end

        // Stage 5: second candidate and packing
        second = '0;
        if (hit_b) second = q.rest[idx_b];
        d.word = {{PAD_W{1'b0}}, second, {PAD_W{1'b0}}, q.win};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_out = q.word;
endmodule

// File: rtl/msp_sector_pipe_chk.sv
module msp_sector_pipe_chk
    import msp_pkg::*;
#(
    parameter int NUM_CAND = 4,
    parameter int MIN_PT   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_CAND*CAND_W-1:0] cand_in,
    input logic [31:0]                word_out
);
    localparam int VA  = CAND_W - 1;
    localparam int VB  = SLOT_W + CAND_W - 1;
    localparam int PAH = CAND_W - 2;
    localparam int PBH = SLOT_W + CAND_W - 2;

    logic       none_valid;
    logic [2:0] warm;

    always_comb begin
        none_valid = 1'b1;
        for (int i = 0; i < NUM_CAND; i++)
            if (cand_in[i*CAND_W + CAND_W - 1]) none_valid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         warm <= '0;
        else if (warm != 5) warm <= warm + 3'd1;
    end

    AST_SLOT_A_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !word_out[VA] |-> word_out[SLOT_W-1:0] == '0); // R8
    AST_SLOT_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !word_out[VB] |-> word_out[31:SLOT_W] == '0); // R8
    AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (!rst_n)
        word_out[VB] |-> word_out[VA]); // R7
    AST_B_NOT_ABOVE_A: assert property (@(posedge clk) disable iff (!rst_n)
        word_out[VB] |-> word_out[PBH -: PT_W] <= word_out[PAH -: PT_W]); // R7
    AST_MIN_PT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        word_out[VA] |-> word_out[PAH -: PT_W] >= PT_W'(MIN_PT)); // R3
    AST_EMPTY_IN_EMPTY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 5 && $past(none_valid, 5)) |-> word_out == '0); // R2
endmodule

bind msp_sector_pipe msp_sector_pipe_chk #(
    .NUM_CAND (NUM_CAND),
    .MIN_PT   (MIN_PT)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand_in  (cand_in),
    .word_out (word_out)
);

// File: tb/test_msp_sector_pipe.sv
module test_msp_sector_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int CW = 13;
    localparam int MIN_PT = 2;
    localparam int CALO_PT = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC*CW-1:0] cand_in = '0;
    logic [NC-1:0]    calo_tag_in = '0;
    logic [31:0]      word_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       lab_q[$];

    msp_sector_pipe #(.NUM_CAND(NC), .MIN_PT(MIN_PT), .CALO_PT(CALO_PT)) i_msp_sector_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_in     (cand_in),
        .calo_tag_in (calo_tag_in),
        .word_out    (word_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [CW-1:0] mk(int v, int pt, int ov, int roi);
        return {v[0], pt[2:0], ov[0], roi[7:0]};
    endfunction

    function automatic logic [31:0] ref_word(logic [NC*CW-1:0] c, logic [NC-1:0] t);
        int  pt[NC];
        int  roi[NC];
        bit  ok[NC];
        bit  fl[NC];
        int  a;
        int  b;
        logic [15:0] sa;
        logic [15:0] sb;
        for (int i = 0; i < NC; i++) begin
            logic [CW-1:0] e;
            e = c[i*CW +: CW];
            ok[i] = e[12]; pt[i] = int'(e[11:9]); fl[i] = e[8]; roi[i] = int'(e[7:0]);
            if (pt[i] < MIN_PT) ok[i] = 0;
            if (pt[i] < CALO_PT && !t[i]) ok[i] = 0;
        end
        for (int k = 0; k + 1 < NC; k += 2)
            if (ok[k] && ok[k+1] && fl[k] && fl[k+1]) begin
                if (pt[k+1] > pt[k]) ok[k] = 0; else ok[k+1] = 0;
            end
        a = -1; b = -1;
        for (int i = 0; i < NC; i++) if (ok[i] && (a < 0 || pt[i] > pt[a])) a = i;
        for (int i = 0; i < NC; i++) if (i != a && ok[i] && (b < 0 || pt[i] > pt[b])) b = i;
        sa = (a < 0) ? 16'h0 : {3'b000, 1'b1, pt[a][2:0], fl[a], roi[a][7:0]};
        sb = (b < 0) ? 16'h0 : {3'b000, 1'b1, pt[b][2:0], fl[b], roi[b][7:0]};
        return {sb, sa};
    endfunction

    task automatic check(string lab, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: word_out got %h expected %h", lab, got, exp);
        end
    endtask

    // One crossing: compare the result due now, then apply a new set
    task automatic step(string lab, logic [NC*CW-1:0] c, logic [NC-1:0] t);
        @(negedge clk);
        if (exp_q.size() == 5) check(lab_q.pop_front(), word_out, exp_q.pop_front());
        cand_in = c;
        calo_tag_in = t;
        exp_q.push_back(ref_word(c, t));
        lab_q.push_back(lab);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: held in reset with live-looking inputs
        cand_in = {mk(1,7,0,9), mk(1,6,0,8), mk(1,5,0,7), mk(1,4,0,6)};
        calo_tag_in = '1;
        repeat (3) @(negedge clk);
        check("R1 during reset", word_out, 32'h0);
        cand_in = '0;
        calo_tag_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back(32'h0);
            lab_q.push_back("R1 after reset");
        end

        // R3: codes 0 and 1 cut, code 2 kept
        step("R3", {mk(0,0,0,0), mk(1,0,0,3), mk(1,2,0,2), mk(1,1,0,1)}, 4'b1111);
        // R4: untagged low code cut, tagged low code kept, high code needs no tag
        step("R4", {mk(0,0,0,0), mk(1,5,0,12), mk(1,4,0,11), mk(1,3,0,10)}, 4'b0010);
        // R4 boundary: code 4 untagged dropped
        step("R4", {mk(0,0,0,0), mk(0,0,0,0), mk(1,4,0,21), mk(1,7,0,20)}, 4'b0000);
        // R5: pair 0/1 higher code wins; pair 2/3 equal codes keep lower index
        step("R5", {mk(1,4,1,33), mk(1,4,1,32), mk(1,6,1,31), mk(1,3,1,30)}, 4'b1111);
        // R5: lower index higher code wins
        step("R5", {mk(0,0,0,0), mk(0,0,0,0), mk(1,2,1,41), mk(1,7,1,40)}, 4'b1111);
        // R9: only one flagged, both kept; flagged partner invalid
        step("R9", {mk(0,7,1,53), mk(1,5,1,52), mk(1,5,0,51), mk(1,6,1,50)}, 4'b1111);
        // R9: flagged partner removed by coincidence first, so no clash
        step("R9", {mk(0,0,0,0), mk(0,0,0,0), mk(1,3,1,61), mk(1,6,1,60)}, 4'b1101);
        // R6: all equal codes, lowest indices win
        step("R6", {mk(1,7,0,73), mk(1,7,0,72), mk(1,7,0,71), mk(1,7,0,70)}, 4'b1111);
        // R6: highest in last position
        step("R6", {mk(1,7,0,83), mk(1,5,0,82), mk(1,6,0,81), mk(1,2,0,80)}, 4'b1111);
        // R7: single survivor leaves slot B empty
        step("R7", {mk(0,0,0,0), mk(1,6,0,91), mk(0,0,0,0), mk(0,0,0,0)}, 4'b0000);
        // R7: tie for second place keeps lower index
        step("R7", {mk(1,3,0,103), mk(1,3,0,102), mk(1,6,0,101), mk(0,0,0,0)}, 4'b1111);
        // R8: nothing valid gives an all-zero word; field placement with full roi
        step("R8", '0, 4'b0000);
        step("R8", {mk(0,0,0,0), mk(0,0,0,0), mk(1,5,1,255), mk(1,7,0,170)}, 4'b0000);
        // R2: back-to-back random sets
        for (int n = 0; n < 60; n++) begin
            logic [NC*CW-1:0] c;
            for (int i = 0; i < NC; i++)
                c[i*CW +: CW] = mk(int'($urandom_range(0,3) != 0), int'($urandom_range(0,7)),
                                   int'($urandom_range(0,1)), int'($urandom_range(0,255)));
            step("R2", c, NC'($urandom));
        end
        // Drain the pipeline
        for (int n = 0; n < 6; n++) step("R2", '0, '0);
        finish_run();
    end
endmodule